// File: doc/BRIEF.md
# Indexed pointer register file

This block keeps a bank of sixteen 16-bit pointer registers and a single shared plus-or-minus-one unit that writes its result back into whichever register an operation selects. Work is paced by a phase sequencer that groups the clock into fixed phases of eight clocks. Every operation lasts two or three whole phases, and nothing starts or finishes between phase boundaries.

A controller issues a request with a 2-bit operation code and a 4-bit register index while `busy_o` is low. Four operations are available:

- Increment a register.
- Decrement a register.
- Load a register from a 16-bit input.
- Fetch through a register: the register drives the memory address, the returned byte is latched into an 8-bit accumulator, and the same register is then incremented.

A debug port reads any register combinationally at any time.

Top module: `ptr_regfile`

## Requirements
- R1: While reset is asserted and right after it, all sixteen registers and the accumulator read zero, and `busy_o`, `done_o` and `mem_rd_o` are low.
- R2: Operation code 3 (load) writes the `load_val_i` value sampled at request acceptance into the selected register. The write is visible when `done_o` is high.
- R3: Operation code 0 (increment) adds one to the selected register, and 0xFFFF wraps to 0x0000.
- R4: Operation code 1 (decrement) subtracts one from the selected register, and 0x0000 wraps to 0xFFFF.
- R5: During a fetch (operation code 2), `mem_rd_o` is high for exactly the 8 clocks of the first phase, and `mem_addr_o` holds the selected register's value throughout. The accumulator takes the byte on `mem_rdata_i` at the last clock of that phase.
- R6: A fetch increments the selected register afterwards, with the same wrap as R3.
- R7: After acceptance, `busy_o` stays high for exactly 24 clocks for a fetch and 16 clocks for the other operations. `done_o` is high for exactly one clock, the first clock in which `busy_o` is low again.
- R8: A request raised while `busy_o` is high is ignored. No register changes because of it, and the running operation keeps its length.
- R9: An operation changes only its selected register. The other fifteen keep their values.
- R10: `dbg_data_o` always shows the register chosen by `dbg_idx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Operation request, taken when busy_o is low |
| op_i | input | 2 | 0 increment, 1 decrement, 2 fetch, 3 load |
| idx_i | input | 4 | Selected register |
| load_val_i | input | 16 | Value for a load |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock completion pulse |
| mem_addr_o | output | 16 | Fetch address |
| mem_rd_o | output | 1 | Fetch read strobe |
| mem_rdata_i | input | 8 | Fetched byte |
| acc_o | output | 8 | Accumulator |
| dbg_idx_i | input | 4 | Debug register select |
| dbg_data_o | output | 16 | Debug register value |

## Verification
The hardest case to reach is a request that arrives in the middle of a running operation, carrying a different register and a load value. The bench raises such a request four clocks into an operation, then reads the other register through the debug port and checks that the busy window did not change length. The wrap cases are reached by first loading 0xFFFF or 0x0000 and then issuing an increment, a decrement or a fetch. The memory model returns a byte computed from the address, so any wrong address or wrong sampling clock shows up in the accumulator.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic [1:0] {
    OP_INC   = 2'd0,
    OP_DEC   = 2'd1,
    OP_FETCH = 2'd2,
    OP_LOAD  = 2'd3
  } ptr_op_e;

  localparam int BASIC_PHASES = 2;
  localparam int FETCH_PHASES = 3;
endpackage

// File: rtl/ptr_phase_seq.sv
module ptr_phase_seq #(
  parameter int PHASE_CLKS = 8,
  parameter int MAX_PHASES = 3,
  parameter int CNT_W      = $clog2(PHASE_CLKS),
  parameter int PH_W       = $clog2(MAX_PHASES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PH_W-1:0]  num_phases_i,
  output logic             busy_o,
  output logic [PH_W-1:0]  phase_o,
  output logic             phase_end_o,
  output logic             final_o,
  output logic             done_o
);
  logic             busy_q, done_q;
  logic [CNT_W-1:0] tick_q;
  logic [PH_W-1:0]  phase_q, last_q;

  assign phase_end_o = busy_q && (tick_q == CNT_W'(PHASE_CLKS - 1));
  assign final_o     = phase_end_o && (phase_q == last_q);
  assign busy_o      = busy_q;
  assign phase_o     = phase_q;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      tick_q  <= '0;
      phase_q <= '0;
      last_q  <= '0;
    end else begin
      done_q <= final_o;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          tick_q  <= '0;
          phase_q <= '0;
          last_q  <= num_phases_i - 1'b1;
        end
      end else if (phase_end_o) begin
        tick_q <= '0;
        if (final_o) begin
          busy_q  <= 1'b0;
          phase_q <= '0;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (phase_q <= last_q)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R7
endmodule

// File: rtl/ptr_step_unit.sv
module ptr_step_unit #(
  parameter int PTR_W = 16
) (
  input  logic [PTR_W-1:0] val_i,
  input  logic             dec_i,
  output logic [PTR_W-1:0] val_o
);
  // modular +/-1, wraps silently
  assign val_o = dec_i ? (val_i - PTR_W'(1)) : (val_i + PTR_W'(1));
endmodule

// File: rtl/ptr_bank.sv
module ptr_bank #(
  parameter int NUM_REGS = 16,
  parameter int PTR_W    = 16,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [PTR_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_a_i,
  output logic [PTR_W-1:0] rdata_a_o,
  input  logic [IDX_W-1:0] raddr_b_i,
  output logic [PTR_W-1:0] rdata_b_o
);
  logic [PTR_W-1:0]    regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] wr_vec;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign wr_vec[g] = we_i && (waddr_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        regs_q[g] <= '0;
      else if (wr_vec[g]) regs_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];

  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_vec)); // R9
endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
  import ptr_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter int PTR_W      = 16,
  parameter int ACC_W      = 8,
  parameter int PHASE_CLKS = 8,
  parameter int IDX_W      = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [1:0]       op_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [PTR_W-1:0] load_val_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [PTR_W-1:0] mem_addr_o,
  output logic             mem_rd_o,
  input  logic [ACC_W-1:0] mem_rdata_i,
  output logic [ACC_W-1:0] acc_o,
  input  logic [IDX_W-1:0] dbg_idx_i,
  output logic [PTR_W-1:0] dbg_data_o
);
  localparam int PH_W = $clog2(FETCH_PHASES + 1);

  ptr_op_e          op_q;
  logic [IDX_W-1:0] sel_q;
  logic [PTR_W-1:0] load_q, sel_val, step_val, wr_data;
  logic [ACC_W-1:0] acc_q;
  logic [PH_W-1:0]  num_phases, phase;
  logic             start, phase_end, final_clk, fetch_phase;

  assign start      = req_i && !busy_o;
  assign num_phases = (ptr_op_e'(op_i) == OP_FETCH) ? PH_W'(FETCH_PHASES)
                                                     : PH_W'(BASIC_PHASES);

  ptr_phase_seq #(.PHASE_CLKS(PHASE_CLKS), .MAX_PHASES(FETCH_PHASES)) u_seq (
    .clk_i, .rst_ni,
    .start_i      (start),
    .num_phases_i (num_phases),
    .busy_o       (busy_o),
    .phase_o      (phase),
    .phase_end_o  (phase_end),
    .final_o      (final_clk),
    .done_o       (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_INC;
      sel_q  <= '0;
      load_q <= '0;
    end else if (start) begin
      op_q   <= ptr_op_e'(op_i);
      sel_q  <= idx_i;
      load_q <= load_val_i;
    end
  end

  ptr_step_unit #(.PTR_W(PTR_W)) u_step (
    .val_i (sel_val),
    .dec_i (op_q == OP_DEC),
    .val_o (step_val)
  );

  assign wr_data = (op_q == OP_LOAD) ? load_q : step_val;

  ptr_bank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_bank (
    .clk_i, .rst_ni,
    .we_i      (final_clk),
    .waddr_i   (sel_q),
    .wdata_i   (wr_data),
    .raddr_a_i (sel_q),
    .rdata_a_o (sel_val),
    .raddr_b_i (dbg_idx_i),
    .rdata_b_o (dbg_data_o)
  );

  assign fetch_phase = busy_o && (op_q == OP_FETCH) && (phase == '0);
  assign mem_rd_o    = fetch_phase;
  assign mem_addr_o  = fetch_phase ? sel_val : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       acc_q <= '0;
    else if (fetch_phase && phase_end) acc_q <= mem_rdata_i;
  end
  assign acc_o = acc_q;

  AST_RD_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> busy_o); // R5
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && $past(mem_rd_o)) |-> $stable(mem_addr_o)); // R5
  AST_ACC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_rd_o |=> $stable(acc_o)); // R5
  AST_SEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(sel_q)); // R8
endmodule

// File: tb/ptr_regfile_test.sv
module ptr_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [1:0]  op;
  logic [3:0]  idx, dbg_idx;
  logic [15:0] load_val, mem_addr, dbg_data;
  logic        busy, done, mem_rd;
  logic [7:0]  mem_rdata, acc;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_regs [16];
  logic [7:0]  exp_acc;

  always #10 clk = ~clk;

  assign mem_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'hA5;

  ptr_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .idx_i(idx),
    .load_val_i(load_val), .busy_o(busy), .done_o(done),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_rdata_i(mem_rdata),
    .acc_o(acc), .dbg_idx_i(dbg_idx), .dbg_data_o(dbg_data)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic chk_all_regs(input string req_tag);
    int bad = 0;
    for (int i = 0; i < 16; i++) begin
      dbg_idx = 4'(i);
      #1;
      if (dbg_data !== exp_regs[i]) begin
        bad++;
        $display("FAIL %s reg%0d actual=%0h expected=%0h", req_tag, i, dbg_data, exp_regs[i]);
      end
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  // issue one op; optional poke = stray request mid-operation
  task automatic run_op(input logic [1:0] o, input logic [3:0] r, input logic [15:0] v,
                        input bit poke, input logic [3:0] poke_idx);
    int busy_cnt = 0, rd_cnt = 0, addr_bad = 0;
    logic [15:0] start_val = exp_regs[r];
    @(negedge clk);
    req = 1'b1; op = o; idx = r; load_val = v;
    @(negedge clk);
    req = 1'b0;
    while (busy && busy_cnt < 100) begin
      busy_cnt++;
      if (mem_rd) begin
        rd_cnt++;
        if (mem_addr !== start_val) addr_bad++;
      end
      if (poke && busy_cnt == 4) begin
        req = 1'b1; op = 2'd3; idx = poke_idx; load_val = 16'hDEAD;
      end else begin
        req = 1'b0;
      end
      @(negedge clk);
    end
    req = 1'b0;
    chk("R7 busy length", 32'(busy_cnt), (o == 2'd2) ? 32'd24 : 32'd16);
    chk("R7 done pulse", {31'd0, done}, 32'd1);
    case (o)
      2'd0: exp_regs[r] = start_val + 16'd1;
      2'd1: exp_regs[r] = start_val - 16'd1;
      2'd2: begin
        exp_regs[r] = start_val + 16'd1;
        exp_acc = start_val[7:0] ^ start_val[15:8] ^ 8'hA5;
        chk("R5 read strobe clocks", 32'(rd_cnt), 32'd8);
        chk("R5 address held", 32'(addr_bad), 32'd0);
        chk("R5 accumulator", {24'd0, acc}, {24'd0, exp_acc});
      end
      default: exp_regs[r] = v;
    endcase
    dbg_idx = r; #1;
    chk("R2 R3 R4 R6 R10 selected reg", {16'd0, dbg_data}, {16'd0, exp_regs[r]});
    @(negedge clk);
    chk("R7 done clears", {31'd0, done}, 32'd0);
    chk_all_regs("R9 other regs");
  endtask

  task automatic t_reset();
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 mem_rd", {31'd0, mem_rd}, 32'd0);
    chk("R1 acc", {24'd0, acc}, 32'd0);
    chk_all_regs("R1 regs zero");
  endtask

  task automatic t_load();
    run_op(2'd3, 4'd2, 16'h1234, 0, 0);   // R2
    run_op(2'd3, 4'd15, 16'hFFFF, 0, 0);  // R2
    run_op(2'd3, 4'd7, 16'h0100, 0, 0);   // R2
  endtask

  task automatic t_inc_dec();
    run_op(2'd0, 4'd2, 16'h0, 0, 0);  // R3
    run_op(2'd0, 4'd15, 16'h0, 0, 0); // R3 wrap to 0
    run_op(2'd1, 4'd7, 16'h0, 0, 0);  // R4
    run_op(2'd1, 4'd15, 16'h0, 0, 0); // R4 wrap to FFFF
    run_op(2'd1, 4'd0, 16'h0, 0, 0);  // R4 wrap from reset value
  endtask

  task automatic t_fetch();
    run_op(2'd2, 4'd2, 16'h0, 0, 0);  // R5 R6
    run_op(2'd2, 4'd7, 16'h0, 0, 0);  // R5 R6
    run_op(2'd2, 4'd15, 16'h0, 0, 0); // R6 wrap FFFF
  endtask

  task automatic t_ignore();
    run_op(2'd0, 4'd9, 16'h0, 1, 4'd4);  // R8 stray load to reg 4
    run_op(2'd2, 4'd3, 16'h0, 1, 4'd3);  // R8 stray load to same reg
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) exp_regs[i] = '0;
    exp_acc = '0;
    rst_n = 1'b0; req = 1'b0; op = '0; idx = '0; load_val = '0; dbg_idx = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_inc_dec();
    t_fetch();
    t_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule